// File: doc/BRIEF.md
# Register Sweep and Reset-Line Tester

This block is a bus master that proves out a peripheral's register file and its hard-reset wire. One `start` pulse runs two phases in a fixed order. The first phase visits a list of fully read/write registers. At each one it writes every byte value in turn and reads it back. The second phase uses a single control register. It loads all ones, confirms the readback, drives the peripheral's reset for a fixed pulse, waits briefly and then expects the register to read back zero.

The first failing comparison ends the run. The block then raises `done` and shows a status code. A clean run also ends with `done` and the pass code. A new `start` pulse after `done` repeats the whole test from its first step, so a failed check can simply be rerun. The register list is computed inside the block from a base address and a stride, one entry per register.

Top module: `regsweep_tester`

## Requirements
- R1: After reset, `done` is 0, `status` is 0x00, `bus_valid` is 0 and `periph_rst` is 0.
- R2: A run visits register addresses REG_BASE + i*REG_STRIDE for i = 0 to NUM_REGS-1, in increasing i. At each address it writes value 0x00, reads it, then writes 0x01 and reads it, and so on up to 0xFF, before moving to the next address.
- R3: If a sweep readback differs from the value just written, the run ends with `done`=1 and `status`=0x05, and no further bus request is made.
- R4: After the sweep, the block writes 0xFF to CTRL_ADDR and reads it back. A readback other than 0xFF ends the run with `status`=0x05 and no reset pulse.
- R5: When that readback is correct, `periph_rst` is high for exactly RST_CYCLES consecutive cycles (at least 4). No bus request is made during the pulse or in the 2 cycles after it. After that the block reads CTRL_ADDR once more.
- R6: If the post-reset readback is 0x00, the run ends with `status`=0x00. Any other value ends it with `status`=0x02.
- R7: A request whose `bus_ready` is low keeps `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` unchanged in the next cycle.
- R8: `start` while idle or done begins a fresh run from the first register and value 0x00, and `done` drops. `start` during a run is ignored.
- R9: `done` and `status` hold their values, with no bus request and no reset pulse, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle or done |
| bus_valid | output | 1 | Request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ready | input | 1 | Request accepted in this cycle |
| bus_rvalid | input | 1 | Read data valid (at least one cycle after the read is accepted) |
| bus_rdata | input | 8 | Read data |
| periph_rst | output | 1 | Active-high hard reset to the peripheral |
| done | output | 1 | Run finished |
| status | output | 8 | 0x00 pass, 0x02 reset error, 0x05 mismatch |

## Verification
The ending of a run and the request to start the next one can land in the same cycle. To provoke this, the bench holds `start` high from the middle of a run until after completion. The pulse that arrives mid-run must be ignored. Once the final comparison is made, `done` must show for exactly one cycle. The bench then checks that the request monitor sees a second, complete sequence that restarts at the first register with value 0x00 and ends with the pass code.

// File: rtl/regsweep_pkg.sv
package regsweep_pkg;

  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] STAT_PASS     = 8'h00;
  localparam logic [DATA_W-1:0] STAT_RESET    = 8'h02;
  localparam logic [DATA_W-1:0] STAT_MISMATCH = 8'h05;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SW_WR,
    ST_SW_RD,
    ST_SW_CHK,
    ST_CT_WR,
    ST_CT_RD,
    ST_CT_CHK,
    ST_PULSE,
    ST_SETTLE,
    ST_CT_RD2,
    ST_CT_CHK2,
    ST_DONE
  } sweep_state_e;

endpackage

// File: rtl/regsweep_addr_map.sv
module regsweep_addr_map #(
  parameter int NUM_REGS   = 51,
  parameter int IDX_W      = 6,
  parameter int ADDR_W     = 8,
  parameter int REG_BASE   = 0,
  parameter int REG_STRIDE = 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [ADDR_W-1:0] tbl [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_entry
    assign tbl[gi] = ADDR_W'(REG_BASE + gi * REG_STRIDE);
  end

  assign addr = (idx <= LAST_IDX) ? tbl[idx] : tbl[0];

endmodule

// File: rtl/regsweep_delay.sv
module regsweep_delay #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en  = load | (cnt_q != '0);
  assign cnt_d   = load ? load_val : cnt_q - 1'b1;
  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // the pulse and settle windows shrink by one every cycle
  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/regsweep_tester.sv
module regsweep_tester
  import regsweep_pkg::*;
#(
  parameter int NUM_REGS   = 51,
  parameter int ADDR_W     = 8,
  parameter int REG_BASE   = 32'h20,
  parameter int REG_STRIDE = 1,
  parameter int CTRL_ADDR  = 32'hF0,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              periph_rst,
  output logic              done,
  output logic [DATA_W-1:0] status
);

  localparam int               IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(NUM_REGS - 1);
  localparam int               SETTLE_CYC = 2;
  localparam int               CNT_W      = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_ADDR);
  localparam logic [DATA_W-1:0] ALL_ONES  = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  sweep_state_e      state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic [DATA_W-1:0] status_q, status_d;
  logic              ptr_en, status_en;
  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] sweep_addr;
  logic              run_start;

  regsweep_addr_map #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE)
  ) u_map (
    .idx (idx_q),
    .addr(sweep_addr)
  );

  regsweep_delay #(.CNT_W(CNT_W)) u_delay (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  assign run_start = start && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    val_d     = val_q;
    status_d  = status_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = sweep_addr;
    bus_wdata = val_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (run_start) begin
        state_d  = ST_SW_WR;
        idx_d    = '0;
        val_d    = '0;
        status_d = STAT_PASS;
      end
      ST_SW_WR: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        if (bus_ready) state_d = ST_SW_RD;
      end
      ST_SW_RD: begin
        bus_valid = 1'b1;
        if (bus_ready) state_d = ST_SW_CHK;
      end
      ST_SW_CHK: if (bus_rvalid) begin
        if (bus_rdata != val_q) begin
          status_d = STAT_MISMATCH;
          state_d  = ST_DONE;
        end else if (val_q == ALL_ONES) begin
          val_d = '0;
          if (idx_q == LAST_IDX) state_d = ST_CT_WR;
          else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_SW_WR;
          end
        end else begin
          val_d   = val_q + 1'b1;
          state_d = ST_SW_WR;
        end
      end
      ST_CT_WR: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = CTRL_A;
        bus_wdata = ALL_ONES;
        if (bus_ready) state_d = ST_CT_RD;
      end
      ST_CT_RD: begin
        bus_valid = 1'b1;
        bus_addr  = CTRL_A;
        if (bus_ready) state_d = ST_CT_CHK;
      end
      ST_CT_CHK: if (bus_rvalid) begin
        if (bus_rdata != ALL_ONES) begin
          status_d = STAT_MISMATCH;
          state_d  = ST_DONE;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RST_CYCLES - 1);
          state_d  = ST_PULSE;
        end
      end
      ST_PULSE: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SETTLE_CYC - 1);
        state_d  = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_expired) state_d = ST_CT_RD2;
      ST_CT_RD2: begin
        bus_valid = 1'b1;
        bus_addr  = CTRL_A;
        if (bus_ready) state_d = ST_CT_CHK2;
      end
      ST_CT_CHK2: if (bus_rvalid) begin
        status_d = (bus_rdata == '0) ? STAT_PASS : STAT_RESET;
        state_d  = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ptr_en    = run_start || (state_q == ST_SW_CHK && bus_rvalid);
  assign status_en = run_start || (state_d == ST_DONE && state_q != ST_DONE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      val_q    <= '0;
      status_q <= STAT_PASS;
    end else begin
      state_q <= state_d;
      if (ptr_en) begin
        idx_q <= idx_d;
        val_q <= val_d;
      end
      if (status_en) status_q <= status_d;
    end
  end

  assign periph_rst = (state_q == ST_PULSE);
  assign done       = (state_q == ST_DONE);
  assign status     = status_q;

  // cycles the reset line has been high, for the width check
  logic [CNT_W-1:0] rst_hi_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     rst_hi_q <= '0;
    else if (periph_rst) rst_hi_q <= rst_hi_q + 1'b1;
    else                 rst_hi_q <= '0;
  end

  assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                   && $stable(bus_write) && $stable(bus_wdata)));

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(periph_rst) |-> (rst_hi_q == CNT_W'(RST_CYCLES)));

  assert_quiet_pulse_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    periph_rst |-> !bus_valid);

  assert_quiet_settle_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(periph_rst) |-> (!bus_valid ##1 !bus_valid));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (!bus_valid && !periph_rst));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !start) |=> (done && $stable(status)));

  assert_status_code_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (status == STAT_PASS || status == STAT_RESET || status == STAT_MISMATCH));

  assert_sweep_idx_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    idx_q <= LAST_IDX);

endmodule

// File: tb/regsweep_tester_test.sv
`timescale 1ns/1ps
module regsweep_tester_test;

  localparam int N      = 4;
  localparam int BASE   = 8'h10;
  localparam int STRIDE = 3;
  localparam int CTRL   = 8'hF0;
  localparam int RSTW   = 5;
  localparam int FULL   = N * 512 + 3;

  typedef struct packed {
    logic [7:0] faddr;
    logic [7:0] fset;
    logic [7:0] fclr;
    logic       rbad;
    logic [7:0] exp_stat;
    logic       exp_pulse;
    int         exp_cnt;
  } scen_t;

  // fault address, bits forced high, bits forced low, reset ignored,
  // expected status, reset pulse expected, expected accepted requests
  localparam scen_t SCEN [7] = '{
    '{8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, FULL},
    '{8'h16, 8'h01, 8'h00, 1'b0, 8'h05, 1'b0, 1026},
    '{8'h10, 8'h00, 8'h80, 1'b0, 8'h05, 1'b0, 258},
    '{8'h19, 8'h00, 8'h40, 1'b0, 8'h05, 1'b0, 1666},
    '{8'hF0, 8'h00, 8'h01, 1'b0, 8'h05, 1'b0, 2050},
    '{8'h00, 8'h00, 8'h00, 1'b1, 8'h02, 1'b1, FULL},
    '{8'hF0, 8'h01, 8'h00, 1'b0, 8'h02, 1'b1, FULL}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       bus_valid, bus_write, bus_ready = 1'b0, bus_rvalid, periph_rst, done;
  logic [7:0] bus_addr, bus_wdata, bus_rdata, status;

  always #2 clk = ~clk;

  regsweep_tester #(
    .NUM_REGS(N), .ADDR_W(8), .REG_BASE(BASE), .REG_STRIDE(STRIDE),
    .CTRL_ADDR(CTRL), .RST_CYCLES(RSTW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .periph_rst(periph_rst), .done(done), .status(status)
  );

  // peripheral model with fault injection
  logic [7:0] mem [256];
  logic [7:0] f_addr = 8'h00, f_set = 8'h00, f_clr = 8'h00;
  logic       f_rbad = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 8'h00;
    end else begin
      bus_rvalid <= 1'b0;
      if (periph_rst && !f_rbad) mem[CTRL] <= 8'h00;
      if (bus_valid && bus_ready) begin
        if (bus_write) mem[bus_addr] <= bus_wdata;
        else begin
          bus_rvalid <= 1'b1;
          bus_rdata  <= (bus_addr == f_addr) ? ((mem[bus_addr] | f_set) & ~f_clr)
                                             : mem[bus_addr];
        end
      end
    end
  end

  // negedge: drive ready, then watch requests and the reset line
  int  tick = 0, seq_e = 0, acc = 0, rst_hi = 0, gap = 0;
  bit  order_bad = 0, quiet_bad = 0, width_bad = 0, pulse_seen = 0;

  function automatic bit exp_req(int e, logic w, logic [7:0] a, logic [7:0] d);
    int r, v, k;
    if (e < N * 512) begin
      r = e / 512;
      v = (e % 512) / 2;
      if (w != ((e % 2) == 0)) return 0;
      if (a != 8'(BASE + r * STRIDE)) return 0;
      if (w && d != 8'(v)) return 0;
      return 1;
    end
    k = e - N * 512;
    if (k == 0) return w && a == 8'(CTRL) && d == 8'hFF;
    if (k == 1 || k == 2) return !w && a == 8'(CTRL);
    return 0;
  endfunction

  always @(negedge clk) begin
    tick++;
    bus_ready = (tick % 3) != 0;
    if (bus_valid && bus_ready) begin
      if (!exp_req(seq_e, bus_write, bus_addr, bus_wdata)) order_bad = 1;
      seq_e++;
      acc++;
    end
    if (periph_rst) begin
      rst_hi++;
      gap = 2;
      pulse_seen = 1;
    end else if (rst_hi != 0) begin
      if (rst_hi != RSTW) width_bad = 1;
      rst_hi = 0;
    end
    if (bus_valid && (periph_rst || gap > 0)) quiet_bad = 1;
    if (!periph_rst && gap > 0) gap--;
  end

  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    seq_e = 0; acc = 0; order_bad = 0; quiet_bad = 0; width_bad = 0; pulse_seen = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic run_once(output bit ok);
    @(negedge clk);
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!done && status == 8'h00 && !bus_valid && !periph_rst, "R1", "reset state",
        {done, bus_valid, periph_rst, status}, 0);

    // table of fault scenarios (each new run is also a rerun, R8)
    foreach (SCEN[s]) begin
      f_addr = SCEN[s].faddr; f_set = SCEN[s].fset;
      f_clr = SCEN[s].fclr;   f_rbad = SCEN[s].rbad;
      run_once(ok);
      chk(ok, "R8", "run reached done", ok, 1);
      chk(status == SCEN[s].exp_stat, "R3/R4/R6", $sformatf("status scen %0d", s),
          status, SCEN[s].exp_stat);
      chk(acc == SCEN[s].exp_cnt, "R3", $sformatf("requests scen %0d", s),
          acc, SCEN[s].exp_cnt);
      chk(!order_bad, "R2", $sformatf("request order scen %0d", s), order_bad, 0);
      chk(pulse_seen == SCEN[s].exp_pulse, "R4", $sformatf("pulse present scen %0d", s),
          pulse_seen, SCEN[s].exp_pulse);
      chk(!width_bad && !quiet_bad, "R5", $sformatf("pulse width and quiet scen %0d", s),
          {width_bad, quiet_bad}, 0);
    end

    // R9: result held after done, no activity
    acc = 0;
    repeat (20) @(negedge clk);
    chk(done && status == 8'h02 && acc == 0 && !pulse_seen == 0, "R9", "hold after done",
        {done, status}, 9'h102);

    // R8: rerun after a failure with the fault removed passes from the start
    f_addr = 8'h16; f_set = 8'h01; f_clr = 8'h00; f_rbad = 1'b0;
    run_once(ok);
    chk(status == 8'h05, "R3", "fault before rerun", status, 5);
    f_set = 8'h00;
    run_once(ok);
    chk(ok && status == 8'h00 && acc == FULL && !order_bad, "R8", "rerun passes",
        acc, FULL);

    // R8: start during a run is ignored
    @(negedge clk);
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R8", "no done after mid-run start", done, 0);
    wait_done(ok);
    chk(ok && acc == FULL && !order_bad && status == 8'h00, "R8", "mid-run start ignored",
        acc, FULL);

    // completion and a held start in the same cycle
    @(negedge clk);
    clear_mon();
    start = 1'b1;
    repeat (500) @(negedge clk);
    wait_done(ok);
    chk(ok && acc == FULL && !order_bad, "R8", "first run under held start", acc, FULL);
    seq_e = 0; acc = 0;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R9", "done lasts one cycle under held start", done, 0);
    wait_done(ok);
    chk(ok && acc == FULL && !order_bad && status == 8'h00, "R2", "restart from first register",
        acc, FULL);
    chk(!width_bad && !quiet_bad, "R5", "pulse after restart", {width_bad, quiet_bad}, 0);

    summary();
    $finish;
  end

endmodule